// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, side A and side B, and keeps one storage register for each direction. Each bus pin is split into three signals: an input from the pin, an output value and an output enable. The block therefore needs no tri-state cells, and the pad ring or bus fabric around it resolves the wire.

Register A samples side A when its one-cycle strobe is high. Register B samples side B on its own strobe. For each output direction a select picks either the live input of the opposite side or the value held in that direction's register. Two enables of opposite polarity decide which sides drive.

A register always samples the effective value of its bus. That is the block's own output when the side is driven and the external pin input when it is not. Because of this, one bus can be copied into both registers through the output path. Everything runs on a single system clock with a synchronous active-low reset.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, both registers clear to zero. After the reset, a side that drives its stored value shows 0.
- R2: At a rising edge with `cap_a` high, register A takes the effective side-A value. With `cap_a` low, register A keeps its value.
- R3: At a rising edge with `cap_b` high, register B takes the effective side-B value. With `cap_b` low, register B keeps its value.
- R4: Capture does not depend on the enables. With both sides undriven (`en_b_hi`=0, `en_a_n`=1), the strobes still load `a_in` and `b_in` into the registers.
- R5: `b_oe` equals `en_b_hi` (active high). `a_oe` equals the inverse of `en_a_n` (active low). An output whose enable is off reads all zeros.
- R6: When `b_oe` is 1, `b_out` follows `a_in` in the same cycle if `sel_a2b` is 0, and shows register A if `sel_a2b` is 1.
- R7: When `a_oe` is 1, `a_out` follows `b_in` in the same cycle if `sel_b2a` is 0, and shows register B if `sel_b2a` is 1.
- R8: With both sides driven and both selects at 1, `b_out` shows register A and `a_out` shows register B at the same time.
- R9: Copying A into both registers uses `en_b_hi`=1, `en_a_n`=1 and `sel_a2b`=0, with both strobes high in one cycle. Both registers then hold the `a_in` value of that cycle. The mirror setup copies B into both registers.
- R10: With `sel_a2b`=1 and `b_oe`=1, raising both strobes in one cycle loads the previous register-A value into register B, while register A takes `a_in`.
- R11: When a side is driven, its register captures the block's own output for that side, computed from state before the edge, and ignores the pin input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | W | Value seen on side A pins |
| a_out | output | W | Value driven toward side A |
| a_oe | output | 1 | Drive enable for side A |
| b_in | input | W | Value seen on side B pins |
| b_out | output | W | Value driven toward side B |
| b_oe | output | 1 | Drive enable for side B |
| cap_a | input | 1 | One-cycle capture strobe for register A |
| cap_b | input | 1 | One-cycle capture strobe for register B |
| sel_a2b | input | 1 | 0: live A to B, 1: register A to B |
| sel_b2a | input | 1 | 0: live B to A, 1: register B to A |
| en_b_hi | input | 1 | Active-high enable for side B drive |
| en_a_n | input | 1 | Active-low enable for side A drive |

## Verification
Capture and output selection can fall in the same cycle when a register samples a bus that the block is driving from the other register. The bench provokes this by raising both strobes together in every enable and select combination, with changing data. A reference model computes each output from the state before the edge and judges the new register contents through the outputs on the following cycle. Directed cases cover the dual store with select low, where both registers get the live value, and with select high, where register B must get the old register-A value.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    DRV_NONE   = 2'd0,
    DRV_A_ONLY = 2'd1,
    DRV_B_ONLY = 2'd2,
    DRV_BOTH   = 2'd3
  } drive_mode_e;

  function automatic drive_mode_e decode_mode(input logic en_b_hi, input logic en_a_n);
    logic drv_a;
    drv_a = ~en_a_n;
    if (drv_a && en_b_hi)      return DRV_BOTH;
    else if (drv_a)            return DRV_A_ONLY;
    else if (en_b_hi)          return DRV_B_ONLY;
    else                       return DRV_NONE;
  endfunction

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic        en_b_hi,
  input  logic        en_a_n,
  output drive_mode_e mode,
  output logic        a_oe,
  output logic        b_oe
);

  always_comb begin
    mode = decode_mode(en_b_hi, en_a_n);
    a_oe = (mode == DRV_A_ONLY) || (mode == DRV_BOTH);
    b_oe = (mode == DRV_B_ONLY) || (mode == DRV_BOTH);
  end

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic load_fire;
  assign load_fire = cap;

  always_ff @(posedge clk) begin
    if (!rst_n)         q <= '0;
    else if (load_fire) q <= d;
  end

  // R2 / R3: a strobe loads the presented value
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> q == $past(d));

  // R2 / R3: no strobe, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> $stable(q));

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int unsigned W = 8
) (
  input  logic         sel_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         oe,
  input  logic [W-1:0] ext_in,
  output logic [W-1:0] out_val,
  output logic [W-1:0] eff_val
);

  function automatic logic [W-1:0] pick(input logic s, input logic [W-1:0] l,
                                        input logic [W-1:0] st);
    return s ? st : l;
  endfunction

  function automatic logic [W-1:0] resolve(input logic drv, input logic [W-1:0] own,
                                           input logic [W-1:0] pin);
    return drv ? own : pin;
  endfunction

  logic [W-1:0] chosen;

  always_comb begin
    chosen  = pick(sel_stored, live, stored);
    out_val = oe ? chosen : '0;
    eff_val = resolve(oe, out_val, ext_in);
  end

  // R5: undriven side reads zero
  always_comb begin
    a_r5_quiet: assert (oe || out_val == '0);
  end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic         sel_a2b,
  input  logic         sel_b2a,
  input  logic         en_b_hi,
  input  logic         en_a_n
);

  drive_mode_e  mode;
  logic [W-1:0] q_a, q_b;
  logic [W-1:0] a_eff, b_eff;
  logic         dual_store;

  xcvr_ctrl u_ctrl (
    .en_b_hi (en_b_hi),
    .en_a_n  (en_a_n),
    .mode    (mode),
    .a_oe    (a_oe),
    .b_oe    (b_oe)
  );

  xcvr_path #(.W(W)) u_to_b (
    .sel_stored (sel_a2b),
    .live       (a_in),
    .stored     (q_a),
    .oe         (b_oe),
    .ext_in     (b_in),
    .out_val    (b_out),
    .eff_val    (b_eff)
  );

  xcvr_path #(.W(W)) u_to_a (
    .sel_stored (sel_b2a),
    .live       (b_in),
    .stored     (q_b),
    .oe         (a_oe),
    .ext_in     (a_in),
    .out_val    (a_out),
    .eff_val    (a_eff)
  );

  xcvr_store #(.W(W)) u_reg_a (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap_a),
    .d     (a_eff),
    .q     (q_a)
  );

  xcvr_store #(.W(W)) u_reg_b (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap_b),
    .d     (b_eff),
    .q     (q_b)
  );

  assign dual_store = cap_a && cap_b;

  // R4: undriven side captures its pin
  a_r4_isolated_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a && !a_oe) |=> q_a == $past(a_in));

  // R6: live A reaches B
  a_r6_live_a2b: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && !sel_a2b) |-> b_out == a_in);

  // R8: both sides show the opposite register
  a_r8_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DRV_BOTH && sel_a2b && sel_b2a) |-> (b_out == q_a && a_out == q_b));

  // R10: simultaneous strobes with stored select pass the old A value
  a_r10_old_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_store && b_oe && sel_a2b) |=> q_b == $past(q_a));

  // R11: a driven side captures its own output
  a_r11_own_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_b && b_oe) |=> q_b == $past(b_out));

endmodule

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;
  logic cap_a = 0, cap_b = 0, sel_a2b = 0, sel_b2a = 0, en_b_hi = 0, en_a_n = 1;

  int total = 0, bad = 0;
  logic [W-1:0] ma = '0, mb = '0;

  always #5 clk = ~clk;

  bus_xcvr_reg #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .cap_a(cap_a), .cap_b(cap_b),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .en_b_hi(en_b_hi), .en_a_n(en_a_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: expected drive toward a side
  function automatic logic [W-1:0] ref_out(input logic en, input logic s,
                                           input logic [W-1:0] live, input logic [W-1:0] st);
    logic [W-1:0] m;
    m = {W{s}};
    return {W{en}} & ((st & m) | (live & ~m));
  endfunction

  // one cycle: drive, check outputs, clock, advance model
  task automatic step(input logic eb, input logic ean, input logic sab, input logic sba,
                      input logic ca, input logic cb, input logic [W-1:0] av,
                      input logic [W-1:0] bv, input string tag);
    logic [W-1:0] eo_a, eo_b, na, nb;
    logic ea, ebo;
    @(negedge clk);
    en_b_hi = eb; en_a_n = ean; sel_a2b = sab; sel_b2a = sba;
    cap_a = ca; cap_b = cb; a_in = av; b_in = bv;
    #1;
    ea   = (ean == 1'b0);
    ebo  = (eb == 1'b1);
    eo_b = ref_out(ebo, sab, av, ma);
    eo_a = ref_out(ea, sba, bv, mb);
    chk({tag, " R5 a_oe"}, {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ea});
    chk({tag, " R5 b_oe"}, {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, ebo});
    chk({tag, " R6 b_out"}, b_out, eo_b);
    chk({tag, " R7 a_out"}, a_out, eo_a);
    // R11: driven side stores its own output; R4 otherwise pin
    na = ca ? (ea ? eo_a : av) : ma;
    nb = cb ? (ebo ? eo_b : bv) : mb;
    @(posedge clk);
    #1;
    ma = na; mb = nb;
    cap_a = 0; cap_b = 0;
  endtask

  // show both registers through the outputs and compare
  task automatic peek(input string req, input logic [W-1:0] ea, input logic [W-1:0] eb);
    @(negedge clk);
    en_b_hi = 1; en_a_n = 0; sel_a2b = 1; sel_b2a = 1; cap_a = 0; cap_b = 0;
    #1;
    chk({req, " regA via b_out"}, b_out, ea);
    chk({req, " regB via a_out"}, a_out, eb);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset clears both registers
    a_in = 8'hA5; b_in = 8'h5A; cap_a = 1; cap_b = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; cap_a = 0; cap_b = 0;
    peek("R1", 8'h00, 8'h00);

    // R4: isolated capture of pins
    step(0, 1, 0, 0, 1, 1, 8'h3C, 8'hC3, "R4");
    peek("R4", 8'h3C, 8'hC3);

    // R2 R3 R6 R7 R11: sweep every control combination twice with varying data
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 64; i++) begin
        logic [W-1:0] av, bv;
        av = 8'(i * 37 + 5 + p * 11);
        bv = 8'(i * 91 + 200 - p * 7);
        step(i[5], i[4], i[3], i[2], i[1], i[0], av, bv, "R2_R3_sweep");
        peek("R2_R3", ma, mb);
      end
    end

    // R8: both sides show stored values
    step(0, 1, 0, 0, 1, 1, 8'h12, 8'h34, "R8 load");
    step(1, 0, 1, 1, 0, 0, 8'hFF, 8'h00, "R8");
    peek("R8", 8'h12, 8'h34);

    // R9: A into both registers, select low, strobes together
    step(1, 1, 0, 0, 1, 1, 8'h9E, 8'h01, "R9 copyA");
    peek("R9", 8'h9E, 8'h9E);
    // R9 mirror: B into both
    step(0, 0, 0, 0, 1, 1, 8'h02, 8'h6B, "R9 copyB");
    peek("R9", 8'h6B, 8'h6B);

    // R10: select high, simultaneous strobes: B gets old A
    step(0, 1, 0, 0, 1, 0, 8'h47, 8'h00, "R10 preload");
    step(1, 1, 1, 0, 1, 1, 8'hD2, 8'h11, "R10");
    peek("R10", 8'hD2, 8'h47);

    // R10 staggered: second strobe after the first completes gives the new A
    step(1, 1, 1, 0, 0, 1, 8'h00, 8'h00, "R10 stagger");
    peek("R10", 8'hD2, 8'hD2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule